// File: doc/BRIEF.md
# Quad Channel Code Latch with Bus Readback

This block is the digital front of a four-channel converter. A host writes 8-bit codes over a shared data bus into four channel latches and can read any latch back over the same bus. Two active-low strobes, a bank-select line and a read/write line choose the operation and the target channel. Each latch value is presented at all times on its own slice of a packed code output, which feeds that channel's converter.

A write is level-sensitive. While the write condition holds, the addressed latch samples the bus on every clock, so its code follows the bus one cycle later. When the strobe or the read/write line goes inactive, the latch keeps the last sample. If both strobes are low during a write, two channels are loaded with the same byte. A read with exactly one strobe low turns on the bus driver and places the addressed latch on the bus. At all other times the bus is left undriven. An asynchronous active-low reset, released through a two-stage synchronizer, clears every latch and turns off the driver.

Top module: `quad_code_latch`

## Requirements
- R1: While reset is applied, and for the cycles until its synchronized release, all four channel codes read zero and `bus_oe` is low.
- R2: With `stb_ab_n` low, `stb_cd_n` high and `rd_nwr` low, channel A (code bits 7:0) is written when `bank_sel` is 1, and channel B (bits 15:8) is written when `bank_sel` is 0.
- R3: With `stb_ab_n` high, `stb_cd_n` low and `rd_nwr` low, channel C (bits 23:16) is written when `bank_sel` is 1, and channel D (bits 31:24) is written when `bank_sel` is 0.
- R4: With both strobes low and `rd_nwr` low, `bank_sel` = 1 writes the same byte into A and C, and `bank_sel` = 0 writes it into B and D.
- R5: While a write to a channel is held, that channel's code equals the `bus_in` value of the previous cycle.
- R6: When a write ends, the channel keeps the `bus_in` value of the last cycle in which the write was active. Channels that are not addressed never change.
- R7: With exactly one strobe low and `rd_nwr` high, `bus_oe` is 1 in the same cycle, and `bus_out` carries the addressed latch, using the channel decode of R2 and R3. No code changes.
- R8: With both strobes high, no code changes, whatever the values of `bank_sel`, `rd_nwr` and `bus_in`, and `bus_oe` is 0.
- R9: With both strobes low and `rd_nwr` high, no code changes and `bus_oe` is 0.
- R10: `bus_oe` is never 1 while `rd_nwr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_ab_n | input | 1 | Active-low strobe for channels A and B |
| stb_cd_n | input | 1 | Active-low strobe for channels C and D |
| bank_sel | input | 1 | 1 selects A or C, 0 selects B or D |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_in | input | 8 | Data bus as seen at the pins |
| bus_out | output | 8 | Readback data for the tri-state driver |
| bus_oe | output | 1 | Drive enable for the bus pins |
| chan_code | output | 32 | Channel codes, A in bits 7:0 up to D in bits 31:24 |

## Verification
Single-strobe writes to each of the four channels show whether the decode separates the strobes from the bank line. Paired writes show whether both channels of a pair load together. A write held over several cycles while the bus changes separates true tracking from a one-shot capture. Ending a write by raising the strobe, and by raising the read/write line, shows which sample is kept. Reads of every channel, hold cycles with the other lines toggled, and a double-strobe read show whether the bus driver turns on only when it should. A long run of random control and data is then checked against the reference model on every clock.

// File: rtl/quad_code_latch_pkg.sv
package quad_code_latch_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2,
    CH_D = 2'd3
  } ch_idx_t;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_t;
endpackage

// File: rtl/qcl_rst_sync.sv
module qcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qcl_cmd_decode.sv
module qcl_cmd_decode
  import quad_code_latch_pkg::*;
(
  input  logic              stb_ab_n,
  input  logic              stb_cd_n,
  input  logic              bank_sel,
  input  logic              rd_nwr,
  output bus_op_t           op,
  output logic [NUM_CH-1:0] wr_en,
  output logic [NUM_CH-1:0] rd_sel
);
  logic              ab_act;
  logic              cd_act;
  logic [NUM_CH-1:0] target;

  always_comb begin
    ab_act = !stb_ab_n;
    cd_act = !stb_cd_n;

    target         = '0;
    target[CH_A]   = ab_act &  bank_sel;
    target[CH_B]   = ab_act & !bank_sel;
    target[CH_C]   = cd_act &  bank_sel;
    target[CH_D]   = cd_act & !bank_sel;

    if (!ab_act && !cd_act)      op = OP_HOLD;
    else if (!rd_nwr)            op = OP_WRITE;
    else if (ab_act ^ cd_act)    op = OP_READ;
    else                         op = OP_HOLD;

    wr_en  = (op == OP_WRITE) ? target : '0;
    rd_sel = (op == OP_READ)  ? target : '0;
  end
endmodule

// File: rtl/qcl_chan_latch.sv
module qcl_chan_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nx;

  always_comb begin
    q_nx = q_r;
    if (load) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/qcl_readback_mux.sv
module qcl_readback_mux
  import quad_code_latch_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NUM_CH-1:0]    sel,
  input  logic [NUM_CH*DW-1:0] codes,
  output logic [DW-1:0]        dout
);
  logic [DW-1:0] acc [NUM_CH+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_or
    assign acc[i+1] = acc[i] | ({DW{sel[i]}} & codes[i*DW +: DW]);
  end

  assign dout = acc[NUM_CH];
endmodule

// File: rtl/quad_code_latch.sv
module quad_code_latch
  import quad_code_latch_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RST_STAGE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb_ab_n,
  input  logic                 stb_cd_n,
  input  logic                 bank_sel,
  input  logic                 rd_nwr,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        bus_out,
  output logic                 bus_oe,
  output logic [NUM_CH*DW-1:0] chan_code
);
  localparam int CODE_W = NUM_CH * DW;

  logic              rst_int_n;
  bus_op_t           op;
  logic [NUM_CH-1:0] wr_en;
  logic [NUM_CH-1:0] rd_sel;
  logic [NUM_CH-1:0] rd_sel_g;
  logic [CODE_W-1:0] codes;

  qcl_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  qcl_cmd_decode u_dec (
    .stb_ab_n (stb_ab_n),
    .stb_cd_n (stb_cd_n),
    .bank_sel (bank_sel),
    .rd_nwr   (rd_nwr),
    .op       (op),
    .wr_en    (wr_en),
    .rd_sel   (rd_sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qcl_chan_latch #(.DW(DW)) u_lat (
      .clk   (clk),
      .rst_n (rst_int_n),
      .load  (wr_en[i]),
      .d     (bus_in),
      .q     (codes[i*DW +: DW])
    );
  end

  assign rd_sel_g = rst_int_n ? rd_sel : '0;

  qcl_readback_mux #(.DW(DW)) u_rb (
    .sel   (rd_sel_g),
    .codes (codes),
    .dout  (bus_out)
  );

  assign bus_oe    = (op == OP_READ) && rst_int_n;
  assign chan_code = codes;
endmodule

// File: rtl/quad_code_latch_chk.sv
module quad_code_latch_chk #(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              stb_ab_n,
  input logic              stb_cd_n,
  input logic              bank_sel,
  input logic              rd_nwr,
  input logic [DW-1:0]     bus_in,
  input logic              bus_oe,
  input logic [4*DW-1:0]   chan_code
);
  AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_oe |-> rd_nwr); // R10

  AST_OE_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_oe |-> (stb_ab_n != stb_cd_n)); // R7

  AST_HOLD_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stb_ab_n && stb_cd_n) |=> $stable(chan_code)); // R8

  AST_READ_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_nwr |=> $stable(chan_code)); // R9

  AST_TRACK_CHAN_A: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!stb_ab_n && !rd_nwr && bank_sel) |=> (chan_code[DW-1:0] == $past(bus_in))); // R5

  AST_TRACK_CHAN_D: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!stb_cd_n && !rd_nwr && !bank_sel) |=> (chan_code[4*DW-1:3*DW] == $past(bus_in))); // R3
endmodule

bind quad_code_latch quad_code_latch_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .stb_ab_n  (stb_ab_n),
  .stb_cd_n  (stb_cd_n),
  .bank_sel  (bank_sel),
  .rd_nwr    (rd_nwr),
  .bus_in    (bus_in),
  .bus_oe    (bus_oe),
  .chan_code (chan_code)
);

// File: tb/sim_quad_code_latch.sv
module sim_quad_code_latch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stb_ab_n, stb_cd_n, bank_sel, rd_nwr;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [31:0] chan_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model [4];

  always #(CLK_P/2) clk = ~clk;

  quad_code_latch u0 (
    .clk(clk), .rst_n(rst_n), .stb_ab_n(stb_ab_n), .stb_cd_n(stb_cd_n),
    .bank_sel(bank_sel), .rd_nwr(rd_nwr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .chan_code(chan_code)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Channel targeted by a strobe/bank combination: -1 if none.
  function automatic int pick(input bit low, input bit ab);
    if (!low) return -1;
    if (ab) return bank_sel ? 0 : 1;
    return bank_sel ? 2 : 3;
  endfunction

  task automatic step(input string req, input bit sa, input bit sc, input bit bk,
                      input bit rw, input logic [7:0] d);
    int  ta, tc, rdch;
    bit  exp_oe;
    stb_ab_n = sa; stb_cd_n = sc; bank_sel = bk; rd_nwr = rw; bus_in = d;
    #1;
    ta = pick(!sa, 1'b1);
    tc = pick(!sc, 1'b0);
    exp_oe = rst_n && rw && ((ta >= 0) != (tc >= 0));
    check(req, "bus_oe", int'(bus_oe), int'(exp_oe));
    if (exp_oe) begin
      rdch = (ta >= 0) ? ta : tc;
      check(req, "bus_out", int'(bus_out), model[rdch]);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) model[i] = 0;
    end else if (!rw) begin
      if (ta >= 0) model[ta] = int'(d);
      if (tc >= 0) model[tc] = int'(d);
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      check(req, $sformatf("code ch%0d", i), int'(chan_code[i*8 +: 8]), model[i]);
  endtask

  task automatic hold(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 1'b1, 1'b1, k[0], k[1], 8'(k * 37));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    rst_n = 1'b0;
    stb_ab_n = 1'b1; stb_cd_n = 1'b1; bank_sel = 1'b0; rd_nwr = 1'b0; bus_in = 8'h00;
    @(negedge clk);
    // R1: reset state, including writes attempted during reset
    step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
    step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 8'hAA);
    hold("R1", 2);
    rst_n = 1'b1;
    hold("R1", 3);

    // R2: channel A then B through strobe A/B
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A);
    hold("R2", 1);
    step("R2", 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3);
    hold("R2", 1);
    // R3: channel C then D through strobe C/D
    step("R3", 1'b1, 1'b0, 1'b1, 1'b0, 8'h81);
    hold("R3", 1);
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E);
    hold("R3", 1);

    // R5: held write to A tracks a changing bus
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 8'h11);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 8'h22);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 8'h33);
    // R6: release by strobe; bus keeps moving, A must stay 33
    step("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'h44);
    step("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'h55);
    // R6: release by rd_nwr while strobe stays low (becomes a read)
    step("R6", 1'b1, 1'b0, 1'b0, 1'b0, 8'h90);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b0, 8'h91);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 8'h92);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 8'h93);

    // R4: paired writes
    step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5);
    hold("R4", 1);
    step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    hold("R4", 1);

    // R7: read each channel
    step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    step("R7", 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b1, 8'hF0);

    // R8: hold with other lines toggled
    for (int k = 0; k < 8; k++) step("R8", 1'b1, 1'b1, k[0], k[1], 8'(8'hE1 + k));
    // R9: both strobes low with read
    step("R9", 1'b0, 1'b0, 1'b1, 1'b1, 8'hDE);
    step("R9", 1'b0, 1'b0, 1'b0, 1'b1, 8'hAD);

    // R10 and all others: random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic [11:0] r;
      r = 12'($urandom);
      step("R10", r[0], r[1], r[2], r[3], r[11:4]);
    end

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) model[i] = 0;
    check("R1", "code after async reset", int'(chan_code), 0);
    hold("R1", 2);
    rst_n = 1'b1;
    hold("R1", 3);
    step("R1", 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);

    finish_run();
  end
endmodule